// File: doc/BRIEF.md
# Up/Down Potentiometer Line Sequencer

This block sits on the host side of a digitally stepped potentiometer that is controlled by three wires: an active-low select, a falling-edge step strobe and a direction level. Logic elsewhere on the chip hands it one command at a time over a valid/ready handshake. Each command carries a direction, a step count and a flag that says whether the new wiper setting should be committed to the target's nonvolatile memory. The sequencer then plays out the full line waveform and pulses done once the target is ready for the next access.

Every timing limit of the target is a nanosecond parameter. It is turned into a count of system clock cycles by rounding up against a clock-period parameter. The strobe high phase is stretched where needed so that a full strobe period also meets its own minimum. The commit decision is made at deselect: select rises with the strobe high to commit, or with the strobe held low to skip the commit. The recovery wait that follows is long after a commit and short otherwise. A shadow copy of the wiper tap is kept in step with each strobe fall. It stops at tap 0 and at the top tap, just as the target does.

Top module: `updown_pot_driver`

## Requirements
- R1: While reset is asserted and in the first cycle after it, sel_n and strobe are 1, cmd_ready is 1, done is 0 and position equals RESET_POS.
- R2: A command is taken only in a cycle with cmd_valid and cmd_ready both 1. cmd_ready is 0 from the cycle after acceptance until the cycle after done. done is high for exactly one cycle. While busy, cmd_valid and the command fields have no effect on the running command.
- R3: After an accepted command that moves the wiper, sel_n falls and dir_up takes the command direction in the cycle after acceptance. The first strobe fall comes exactly SETUP cycles later, where SETUP is the larger of the rounded-up select setup and direction setup times.
- R4: While selected, each strobe low phase lasts exactly LOW cycles (rounded-up low time). Each high phase lasts exactly HIGH cycles: the larger of the rounded-up high time and the rounded-up period minus LOW.
- R5: Strobe falls exactly cmd_steps times per command, all with sel_n at 0. dir_up stays constant while sel_n is 0 (1 means toward the top tap).
- R6: position moves one tap per strobe fall, in the direction given by dir_up. It stays at 0 when stepping down and at MAX_POS when stepping up.
- R7: With the commit flag set and a nonzero count, strobe rises after the last low phase. sel_n rises exactly max(HIGH, DESEL) cycles later, with strobe at 1.
- R8: With the commit flag clear and a nonzero count, strobe stays 0 after its last fall. sel_n rises exactly LOW + DESEL cycles after that fall, with strobe at 0.
- R9: done is seen exactly STORE_REC cycles after sel_n rises when committing, and NOSTORE_REC cycles after otherwise. strobe is back at 1 by then.
- R10: A zero count with the commit flag set gives a select with no strobe fall. sel_n rises exactly SETUP + DESEL cycles after it fell, with strobe at 1.
- R11: A zero count with the commit flag clear leaves sel_n and strobe at 1 throughout, and done is seen in the cycle right after acceptance.
- R12: Every nanosecond limit is converted to cycles by dividing by CLK_PERIOD_NS and rounding up, with a minimum of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, command can be taken |
| cmd_dir_up | input | 1 | 1 steps toward the top tap, 0 toward tap 0 |
| cmd_steps | input | STEP_W | Number of strobe pulses |
| cmd_store | input | 1 | 1 commits the final setting at deselect |
| done | output | 1 | One-cycle completion pulse after recovery |
| sel_n | output | 1 | Target select, active low |
| strobe | output | 1 | Step strobe, target acts on its falling edge |
| dir_up | output | 1 | Direction level to the target |
| position | output | POS_W | Shadow copy of the wiper tap |

## Verification
The cycle where the wiper steps and the cycle where the target could commit are kept apart: one happens at a strobe fall with select low, the other at a select rise. The bench provokes the case where these could meet by ending commands both ways (strobe high or strobe low at deselect). It also runs zero-step commands, where a select is followed by a deselect with no fall at all, and saturating runs past both ends. For every select rise it checks the strobe level and the exact cycle distance from the last strobe edge. It also checks the total number of falls, so a stray step that meets a commit would show up as a wrong fall count or a wrong level at deselect.

// File: rtl/pot_drv_pkg.sv
package pot_drv_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_LOW, ST_HIGH, ST_TAIL, ST_RECOVER, ST_FIN
  } drv_state_e;

  // nanoseconds to clock cycles, rounded up, never below one cycle
  function automatic int ns_to_cyc(input int ns, input int period_ns);
    int c;
    c = (ns + period_ns - 1) / period_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pot_phase_timer.sv
module pot_phase_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         phase_end
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign phase_end = (cnt_q == '0);

  // the count only moves down by one or is reloaded (R4)
  p_timer_monotonic_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(load) && $past(cnt_q) != '0 |-> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/pot_shadow_pos.sv
module pot_shadow_pos #(
  parameter int MAX_POS   = 99,
  parameter int RESET_POS = 0,
  parameter int POS_W     = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  input  logic             step_up,
  output logic [POS_W-1:0] pos
);
  localparam logic [POS_W-1:0] TOP  = POS_W'(MAX_POS);
  localparam logic [POS_W-1:0] INIT = POS_W'(RESET_POS);

  logic at_top, at_bottom;
  assign at_top    = (pos == TOP);
  assign at_bottom = (pos == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos <= INIT;
    else if (step_en) begin
      if (step_up && !at_top)        pos <= pos + 1'b1;
      else if (!step_up && !at_bottom) pos <= pos - 1'b1;
    end
  end

  p_pos_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pos <= TOP);
  p_pos_sat_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
    step_en && step_up && at_top |=> pos == TOP);
  p_pos_sat_bottom_r6: assert property (@(posedge clk) disable iff (!rst_n)
    step_en && !step_up && at_bottom |=> pos == '0);
  p_pos_still_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(pos));
endmodule

// File: rtl/updown_pot_driver.sv
module updown_pot_driver
  import pot_drv_pkg::*;
#(
  parameter int CLK_PERIOD_NS  = 20,
  parameter int T_SEL_SETUP_NS = 50,
  parameter int T_DIR_SETUP_NS = 1000,
  parameter int T_LOW_NS       = 960,
  parameter int T_HIGH_NS      = 960,
  parameter int T_PERIOD_NS    = 2000,
  parameter int T_DESEL_NS     = 1000,
  parameter int T_STORE_NS     = 10000000,
  parameter int T_NOSTORE_NS   = 100,
  parameter int MAX_POS        = 99,
  parameter int RESET_POS      = 0,
  parameter int STEP_W         = 7,
  localparam int POS_W         = $clog2(MAX_POS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_dir_up,
  input  logic [STEP_W-1:0] cmd_steps,
  input  logic              cmd_store,
  output logic              done,
  output logic              sel_n,
  output logic              strobe,
  output logic              dir_up,
  output logic [POS_W-1:0]  position
);
  // cycle budgets (R12)
  localparam int SETUP_CYC = imax(ns_to_cyc(T_SEL_SETUP_NS, CLK_PERIOD_NS),
                                  ns_to_cyc(T_DIR_SETUP_NS, CLK_PERIOD_NS));
  localparam int LOW_CYC   = ns_to_cyc(T_LOW_NS, CLK_PERIOD_NS);
  localparam int PER_CYC   = imax(ns_to_cyc(T_PERIOD_NS, CLK_PERIOD_NS), LOW_CYC + 1);
  localparam int HIGH_CYC  = imax(ns_to_cyc(T_HIGH_NS, CLK_PERIOD_NS), PER_CYC - LOW_CYC);
  localparam int DESEL_CYC = ns_to_cyc(T_DESEL_NS, CLK_PERIOD_NS);
  localparam int CTAIL_CYC = imax(HIGH_CYC, DESEL_CYC);
  localparam int SREC_CYC  = ns_to_cyc(T_STORE_NS, CLK_PERIOD_NS);
  localparam int NREC_CYC  = ns_to_cyc(T_NOSTORE_NS, CLK_PERIOD_NS);
  localparam int MAX_CYC   = imax(imax(imax(SETUP_CYC, LOW_CYC), imax(HIGH_CYC, CTAIL_CYC)),
                                  imax(SREC_CYC, imax(NREC_CYC, DESEL_CYC)));
  localparam int TMR_W     = $clog2(MAX_CYC + 1);

  localparam logic [TMR_W-1:0] L_SETUP = TMR_W'(SETUP_CYC - 1);
  localparam logic [TMR_W-1:0] L_LOW   = TMR_W'(LOW_CYC - 1);
  localparam logic [TMR_W-1:0] L_HIGH  = TMR_W'(HIGH_CYC - 1);
  localparam logic [TMR_W-1:0] L_DESEL = TMR_W'(DESEL_CYC - 1);
  localparam logic [TMR_W-1:0] L_CTAIL = TMR_W'(CTAIL_CYC - 1);
  localparam logic [TMR_W-1:0] L_SREC  = TMR_W'(SREC_CYC - 1);
  localparam logic [TMR_W-1:0] L_NREC  = TMR_W'(NREC_CYC - 1);

  drv_state_e        state_q, state_d;
  logic              sel_q, sel_d, stb_q, stb_d, dir_q, dir_d, store_q, store_d;
  logic [STEP_W-1:0] left_q, left_d;
  logic              tmr_load, phase_end;
  logic [TMR_W-1:0]  tmr_val;

  // named events for the checks below
  logic cmd_accept, step_fire, sel_release;
  assign cmd_accept  = cmd_valid && (state_q == ST_IDLE);
  assign sel_release = !sel_q && sel_d;

  always_comb begin
    state_d   = state_q;
    sel_d     = sel_q;
    stb_d     = stb_q;
    dir_d     = dir_q;
    store_d   = store_q;
    left_d    = left_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    step_fire = 1'b0;
    unique case (state_q)
      ST_IDLE: if (cmd_accept) begin
        dir_d   = cmd_dir_up;
        store_d = cmd_store;
        left_d  = cmd_steps;
        if (cmd_steps == '0 && !cmd_store) state_d = ST_FIN;
        else begin
          sel_d = 1'b0; state_d = ST_SETUP; tmr_load = 1'b1; tmr_val = L_SETUP;
        end
      end
      ST_SETUP: if (phase_end) begin
        tmr_load = 1'b1;
        if (left_q == '0) begin
          state_d = ST_TAIL; tmr_val = L_DESEL;
        end else begin
          stb_d = 1'b0; step_fire = 1'b1; left_d = left_q - 1'b1;
          state_d = ST_LOW; tmr_val = L_LOW;
        end
      end
      ST_LOW: if (phase_end) begin
        tmr_load = 1'b1;
        if (left_q == '0) begin
          state_d = ST_TAIL;
          if (store_q) begin stb_d = 1'b1; tmr_val = L_CTAIL; end
          else tmr_val = L_DESEL;
        end else begin
          stb_d = 1'b1; state_d = ST_HIGH; tmr_val = L_HIGH;
        end
      end
      ST_HIGH: if (phase_end) begin
        stb_d = 1'b0; step_fire = 1'b1; left_d = left_q - 1'b1;
        state_d = ST_LOW; tmr_load = 1'b1; tmr_val = L_LOW;
      end
      ST_TAIL: if (phase_end) begin
        sel_d = 1'b1; state_d = ST_RECOVER; tmr_load = 1'b1;
        tmr_val = store_q ? L_SREC : L_NREC;
      end
      ST_RECOVER: if (phase_end) begin
        stb_d = 1'b1; state_d = ST_FIN;
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sel_q   <= 1'b1;
      stb_q   <= 1'b1;
      dir_q   <= 1'b0;
      store_q <= 1'b0;
      left_q  <= '0;
    end else begin
      state_q <= state_d;
      sel_q   <= sel_d;
      stb_q   <= stb_d;
      dir_q   <= dir_d;
      store_q <= store_d;
      left_q  <= left_d;
    end
  end

  pot_phase_timer #(.W(TMR_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .phase_end(phase_end)
  );

  pot_shadow_pos #(.MAX_POS(MAX_POS), .RESET_POS(RESET_POS), .POS_W(POS_W)) shadow_i (
    .clk(clk), .rst_n(rst_n), .step_en(step_fire), .step_up(dir_q), .pos(position)
  );

  assign cmd_ready = (state_q == ST_IDLE);
  assign done      = (state_q == ST_FIN);
  assign sel_n     = sel_q;
  assign strobe    = stb_q;
  assign dir_up    = dir_q;

  p_reset_lines_r1: assert property (@(posedge clk)
    !rst_n |=> sel_n && strobe && cmd_ready);
  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !cmd_ready);
  p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && cmd_ready);
  p_fall_only_selected_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe) |-> !sel_n && $past(!sel_n));
  p_dir_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_n && $past(!sel_n) |-> $stable(dir_up));
  p_step_matches_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire |=> $fell(strobe));
  p_commit_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sel_release |=> strobe == store_q);
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> sel_n && strobe);
endmodule

// File: tb/updown_pot_driver_tb_top.sv
`timescale 1ns/1ps
module updown_pot_driver_tb_top;
  localparam int P       = 20;
  localparam int LOW_NS  = 970;
  localparam int HIGH_NS = 950;
  localparam int STOR_NS = 30000;
  localparam int STEP_W  = 7;
  localparam int TOPTAP  = 99;

  function automatic int up_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction
  function automatic int bigger(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // expected budgets, from the requirements
  localparam int E_SETUP = bigger(up_div(50, P), up_div(1000, P));
  localparam int E_LOW   = up_div(LOW_NS, P);
  localparam int E_HIGH  = bigger(up_div(HIGH_NS, P), up_div(2000, P) - E_LOW);
  localparam int E_DESEL = up_div(1000, P);
  localparam int E_SREC  = up_div(STOR_NS, P);
  localparam int E_NREC  = up_div(100, P);

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_dir_up = 1'b0, cmd_store = 1'b0;
  logic [STEP_W-1:0] cmd_steps = '0;
  logic cmd_ready, done, sel_n, strobe, dir_up;
  logic [6:0] position;

  always #(P/2) clk = ~clk;

  updown_pot_driver #(
    .CLK_PERIOD_NS(P), .T_LOW_NS(LOW_NS), .T_HIGH_NS(HIGH_NS), .T_STORE_NS(STOR_NS),
    .MAX_POS(TOPTAP), .RESET_POS(0), .STEP_W(STEP_W)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_dir_up(cmd_dir_up), .cmd_steps(cmd_steps), .cmd_store(cmd_store),
    .done(done), .sel_n(sel_n), .strobe(strobe), .dir_up(dir_up), .position(position)
  );

  int n_checks = 0, n_err = 0;
  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // port monitor, samples at the falling clock edge
  int cyc = 0, t_self = 0, t_selr = 0, t_fall = 0, t_rise = 0, t_edge = 0;
  int falls = 0, dir_bad = 0, first_gap = 0, sel_fell_seen = 0, stb_at_selr = 0;
  logic exp_dir = 1'b0, prev_sel = 1'b1, prev_stb = 1'b1;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (prev_sel && !sel_n) begin t_self = cyc; sel_fell_seen = 1; end
      if (!prev_sel && sel_n) begin t_selr = cyc; stb_at_selr = int'(strobe); end
      if (prev_stb && !strobe) begin
        falls++;
        if (dir_up != exp_dir) dir_bad++;
        if (falls == 1) first_gap = cyc - t_self;
        else if (!sel_n) chk("R4 high phase", cyc - t_rise, E_HIGH);
        t_fall = cyc; t_edge = cyc;
      end
      if (!prev_stb && strobe && !sel_n) begin
        chk("R4 low phase", cyc - t_fall, E_LOW);
        t_rise = cyc; t_edge = cyc;
      end
    end
    prev_sel = sel_n;
    prev_stb = strobe;
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  int exp_pos = 0;

  task automatic run_cmd(input logic up, input int steps, input logic store, input bit poke);
    int guard, t_acc, t_done;
    guard = 0;
    while (!cmd_ready && guard < 100) begin tick(); guard++; end
    falls = 0; dir_bad = 0; sel_fell_seen = 0; first_gap = -1; exp_dir = up;
    cmd_dir_up = up; cmd_steps = STEP_W'(steps); cmd_store = store; cmd_valid = 1'b1;
    tick();
    cmd_valid = 1'b0;
    t_acc = cyc;
    chk("R2 ready low after accept", int'(cmd_ready), 0);
    if (poke) begin
      cmd_valid = 1'b1; cmd_dir_up = !up; cmd_steps = STEP_W'(9); cmd_store = !store;
      repeat (20) tick();
      cmd_valid = 1'b0;
    end
    guard = 0;
    while (!done && guard < 20000) begin tick(); guard++; end
    t_done = cyc;
    chk("R2 done seen", int'(done), 1);
    for (int k = 0; k < steps; k++) begin
      if (up && exp_pos < TOPTAP) exp_pos++;
      else if (!up && exp_pos > 0) exp_pos--;
    end
    if (steps == 0 && !store) begin
      chk("R11 done right after accept", t_done - t_acc, 0);
      chk("R11 no select", sel_fell_seen, 0);
      chk("R11 no strobe fall", falls, 0);
    end else begin
      chk("R5 fall count", falls, steps);
      chk("R5 dir level at falls", dir_bad, 0);
      if (steps > 0) chk("R3 select to first fall", first_gap, E_SETUP);
      if (store && steps > 0) begin
        chk("R7 strobe high at deselect", stb_at_selr, 1);
        chk("R7 last rise to deselect", t_selr - t_edge, bigger(E_HIGH, E_DESEL));
      end else if (store) begin
        chk("R10 strobe high at deselect", stb_at_selr, 1);
        chk("R10 select width", t_selr - t_self, E_SETUP + E_DESEL);
      end else begin
        chk("R8 strobe low at deselect", stb_at_selr, 0);
        chk("R8 last fall to deselect", t_selr - t_fall, E_LOW + E_DESEL);
      end
      chk("R9 recovery length", t_done - t_selr, store ? E_SREC : E_NREC);
    end
    chk("R9 lines idle at done", int'(sel_n && strobe), 1);
    chk("R6 shadow position", int'(position), exp_pos);
    tick();
    chk("R2 done single cycle", int'(done), 0);
    chk("R2 ready after done", int'(cmd_ready), 1);
    if (poke) begin
      repeat (3) tick();
      chk("R2 busy-time request ignored", int'(sel_n), 1);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    chk("R1 select high in reset", int'(sel_n), 1);
    chk("R1 strobe high in reset", int'(strobe), 1);
    @(negedge clk);
    rst_n = 1'b1;
    tick();
    chk("R1 select high", int'(sel_n), 1);
    chk("R1 strobe high", int'(strobe), 1);
    chk("R1 ready", int'(cmd_ready), 1);
    chk("R1 done low", int'(done), 0);
    chk("R1 reset position", int'(position), 0);
    // sweep of small counts, both directions, both endings (R6 floor included)
    for (int s = 1; s <= 3; s++)
      for (int d = 0; d < 2; d++)
        for (int c = 0; c < 2; c++)
          run_cmd(d[0], s, c[0], 1'b0);
    run_cmd(1'b1, 0, 1'b1, 1'b0);   // R10
    run_cmd(1'b0, 0, 1'b0, 1'b0);   // R11
    run_cmd(1'b1, 2, 1'b1, 1'b1);   // R2 busy request
    run_cmd(1'b1, 110, 1'b0, 1'b0); // R6 top saturation
    run_cmd(1'b0, 3, 1'b1, 1'b0);
    run_cmd(1'b0, 100, 1'b1, 1'b0); // R6 bottom saturation
    // R12: rounded-up budgets are what every length check above compares to
    chk("R12 rounded low budget", E_LOW, 49);
    finish_run();
  end
endmodule